// File: doc/BRIEF.md
# ADC Self-Test Sequencer and Window Checker

This block runs built-in self tests on a successive-approximation converter. Software loads a lower and an upper bound for every test step, then starts one of two fixed algorithms. The supply algorithm runs three measurements: bandgap, converter supply and converter reference. The capacitive algorithm runs twelve conversions, one for each sampling-DAC capacitor setting. For every step the block sends a conversion request on a channel reserved for testing, waits for the returned code and checks it against that step's bounds.

A window violation or an overrun of the programmed run-time limit raises a sticky fault meant for an external fault-collection unit. The block also reports the first step that failed. An overrun aborts the run. The converter itself lies outside the block and is seen only as a request/response pair.

Top module: `adc_bist_seq`

## Requirements
- R1: The supply algorithm issues steps 0, 1, 2 in that order. The capacitive algorithm issues steps 0 to 11 in order. Each step issues exactly one request, and the algorithm stays fixed for the whole run (`run_alg` 0 = supply, 1 = capacitive).
- R2: Each request is a one-cycle `conv_req` pulse with `conv_chan` equal to `TEST_CHAN` (default 15).
- R3: A step passes when lower <= code <= upper, with both bounds inclusive. Any other code sets `fault_win` and `fault`.
- R4: Each step is checked against its own bound pair. Capacitive step k is at address k and supply step k is at address 0x10+k. The lower bound goes in `wr_data[DATA_W-1:0]` and the upper bound in `wr_data[2*DATA_W-1:DATA_W]`. After reset the bounds are lower 0 and upper all ones.
- R5: `fail_step` holds the index of the first failing step since the last clear. A later failure leaves it unchanged.
- R6: `fault_win` and `fault_wdog` stay set until a write to address 0x18 with bit 2 set. Neither a new run nor a passing run clears them. The clear also returns `fail_step` to 0.
- R7: A write to address 0x18 with bit 0 set starts a run, and bit 1 selects the algorithm (1 = capacitive). A start written while `busy` is high is ignored.
- R8: The limit L is written to address 0x19, bits [WD_W-1:0]. When the start is captured on edge 0 and the run has not finished, edge L+1 sets `fault_wdog` and drops `busy`, and no further request is issued.
- R9: When the final step's response arrives on the same edge as the limit, the run completes without a timeout. A response arriving after an abort is ignored.
- R10: After reset, `busy`, `conv_req`, `fault`, `fault_win`, `fault_wdog` and `fail_step` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 2*DATA_W | Register write data |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | CHAN_W | Test channel number |
| run_alg | output | 1 | Running algorithm, 1 = capacitive |
| step_idx | output | 4 | Current step index, also the DAC setting |
| rsp_valid | input | 1 | Conversion result valid |
| rsp_data | input | DATA_W | Conversion result code |
| busy | output | 1 | Run in progress |
| fail_step | output | 4 | First failing step since clear |
| fault | output | 1 | Any fault, to the fault-collection unit |
| fault_win | output | 1 | Sticky window fault |
| fault_wdog | output | 1 | Sticky run-time fault |

## Verification
The final step's response and the expiry of the run-time limit can land on the same clock edge. The bench derives the run length from the responder delay: each step takes two cycles plus the delay, so a three-step supply run with a delay of one finishes on edge 9. It then programs limit 8, where completion and expiry coincide and no timeout may be flagged. It also programs limit 7, where the abort must happen one edge before the final response, which must then be ignored. Both cases are judged only at the ports, from `fault_wdog`, `busy` and the count of requests issued.

// File: rtl/adc_bist_pkg.sv
// Shared constants, register map and state type for the ADC self-test block.
// Assumes the step counts are fixed by the two algorithms.
package adc_bist_pkg;
    localparam int NUM_SUP = 3;
    localparam int NUM_CAP = 12;
    localparam int NUM_THR = NUM_SUP + NUM_CAP;
    localparam int STEP_W  = $clog2(NUM_CAP);
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] ADDR_SUP_BASE = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 5'h18;
    localparam logic [ADDR_W-1:0] ADDR_WDOG     = 5'h19;

    localparam int CTRL_START = 0;
    localparam int CTRL_ALG   = 1;
    localparam int CTRL_CLR   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    // Register address of bound entry idx (capacitive entries first).
    function automatic logic [ADDR_W-1:0] thr_addr(input int idx);
        if (idx < NUM_CAP) return ADDR_W'(idx);
        return ADDR_SUP_BASE + ADDR_W'(idx - NUM_CAP);
    endfunction
endpackage

// File: rtl/adc_bist_regs.sv
// Bound storage, run-time limit register and control decode.
// Holds one lower/upper pair per step of both algorithms and serves the pair
// for the current step. Control writes are decoded into single-cycle strobes.
// Assumes WD_W <= 2*DATA_W.
module adc_bist_regs
    import adc_bist_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int WD_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [2*DATA_W-1:0]  wr_data,
    input  logic                 rd_alg,
    input  logic [STEP_W-1:0]    rd_step,
    output logic [DATA_W-1:0]    thr_lo,
    output logic [DATA_W-1:0]    thr_hi,
    output logic [WD_W-1:0]      wd_limit,
    output logic                 start_wr,
    output logic                 alg_wr,
    output logic                 clr_wr
);
    logic [DATA_W-1:0] lo_q [NUM_THR];
    logic [DATA_W-1:0] hi_q [NUM_THR];
    logic [WD_W-1:0]   wd_q;
    logic              ctrl_hit;
    int                rd_idx;

    // Capture bound pairs written to their step addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THR; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '1;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_THR; i++) begin
                if (wr_addr == thr_addr(i)) begin
                    lo_q[i] <= wr_data[DATA_W-1:0];
                    hi_q[i] <= wr_data[2*DATA_W-1:DATA_W];
                end
            end
        end
    end

    // Capture the run-time limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wd_q <= '1;
        else if (wr_en && wr_addr == ADDR_WDOG)    wd_q <= wr_data[WD_W-1:0];
    end

    // Decode control-register writes into strobes.
    always_comb begin
        ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);
        start_wr = ctrl_hit && wr_data[CTRL_START];
        alg_wr   = wr_data[CTRL_ALG];
        clr_wr   = ctrl_hit && wr_data[CTRL_CLR];
    end

    // Select the bound pair for the running algorithm and step.
    always_comb begin
        rd_idx = rd_alg ? int'(rd_step) : NUM_CAP + int'(rd_step);
        thr_lo = '0;
        thr_hi = '1;
        if (rd_idx < NUM_THR) begin
            thr_lo = lo_q[rd_idx];
            thr_hi = hi_q[rd_idx];
        end
    end

    assign wd_limit = wd_q;
endmodule

// File: rtl/adc_bist_window.sv
// Window comparator: flags a code outside [lo, hi]. Both bounds are inclusive.
// Assumes lo <= hi; if not, every code fails.
module adc_bist_window #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] code,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output logic              fail
);
    // Strict comparisons so that equality with either bound passes.
    always_comb fail = (code > hi) || (code < lo);
endmodule

// File: rtl/adc_bist_wdog.sv
// Run-time watchdog. Restarts at an accepted start and counts cycles while
// the run is active. Expires when the count equals the limit. Holds at the
// limit so that it cannot wrap.
module adc_bist_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_ok,
    input  logic            run,
    input  logic [WD_W-1:0] limit,
    output logic            expire
);
    logic [WD_W-1:0] cnt_q;

    // Cycle counter since the start of the run.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (start_ok)                cnt_q <= '0;
        else if (run && cnt_q != limit)   cnt_q <= cnt_q + 1'b1;
    end

    // Expiry is only meaningful while a run is active.
    always_comb expire = run && (cnt_q == limit);
endmodule

// File: rtl/adc_bist_ctrl.sv
// Step sequencer with sticky fault capture. Issues one request per step,
// waits for the response, and advances to the algorithm's last step. An
// expired watchdog aborts the run unless the final response arrives on that
// same edge. A new fault event wins over a clear in the same cycle.
module adc_bist_ctrl
    import adc_bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              alg_wr,
    input  logic              clr_wr,
    input  logic              rsp_valid,
    input  logic              win_fail,
    input  logic              expire,
    output logic              start_ok,
    output logic              busy,
    output logic              conv_req,
    output logic [STEP_W-1:0] step,
    output logic              alg,
    output logic              fault_win,
    output logic              fault_wdog,
    output logic [STEP_W-1:0] fail_step
);
    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_step;
    logic [STEP_W-1:0] fail_step_q;
    logic              alg_q;
    logic              done_now;
    logic              abort;
    logic              fail_ev;
    logic              win_q;
    logic              wdog_q;

    // Per-cycle events derived from state and inputs.
    always_comb begin
        last_step = alg_q ? STEP_W'(NUM_CAP - 1) : STEP_W'(NUM_SUP - 1);
        done_now  = (state_q == ST_WAIT) && rsp_valid && (step_q == last_step);
        abort     = expire && !done_now;
        fail_ev   = (state_q == ST_WAIT) && rsp_valid && win_fail && !abort;
        start_ok  = start_wr && (state_q == ST_IDLE);
    end

    // Sequencer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            alg_q   <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_wr) begin
                        alg_q   <= alg_wr;
                        step_q  <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (step_q == last_step) begin
                            state_q <= ST_IDLE;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky fault flags and first-failure step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q       <= 1'b0;
            wdog_q      <= 1'b0;
            fail_step_q <= '0;
        end else begin
            win_q  <= fail_ev | (win_q & ~clr_wr);
            wdog_q <= abort | (wdog_q & ~clr_wr);
            if (fail_ev && (!win_q || clr_wr)) fail_step_q <= step_q;
            else if (clr_wr)                   fail_step_q <= '0;
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign conv_req   = (state_q == ST_ISSUE);
    assign step       = step_q;
    assign alg        = alg_q;
    assign fault_win  = win_q;
    assign fault_wdog = wdog_q;
    assign fail_step  = fail_step_q;
endmodule

// File: rtl/adc_bist_seq.sv
// Top of the ADC self-test sequencer. Joins the bound registers, the window
// comparator, the run-time watchdog and the step sequencer. Assumes the
// converter answers each request with exactly one rsp_valid pulse.
module adc_bist_seq
    import adc_bist_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int CHAN_W    = 4,
    parameter int TEST_CHAN = 15,
    parameter int WD_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*DATA_W-1:0] wr_data,
    output logic                conv_req,
    output logic [CHAN_W-1:0]   conv_chan,
    output logic                run_alg,
    output logic [STEP_W-1:0]   step_idx,
    input  logic                rsp_valid,
    input  logic [DATA_W-1:0]   rsp_data,
    output logic                busy,
    output logic [STEP_W-1:0]   fail_step,
    output logic                fault,
    output logic                fault_win,
    output logic                fault_wdog
);
    logic [DATA_W-1:0] thr_lo;
    logic [DATA_W-1:0] thr_hi;
    logic [WD_W-1:0]   wd_limit;
    logic              start_wr;
    logic              alg_wr;
    logic              clr_wr;
    logic              win_fail;
    logic              expire;
    logic              start_ok;

    adc_bist_regs #(.DATA_W(DATA_W), .WD_W(WD_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_alg   (run_alg),
        .rd_step  (step_idx),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .wd_limit (wd_limit),
        .start_wr (start_wr),
        .alg_wr   (alg_wr),
        .clr_wr   (clr_wr)
    );

    adc_bist_window #(.DATA_W(DATA_W)) win_i (
        .code (rsp_data),
        .lo   (thr_lo),
        .hi   (thr_hi),
        .fail (win_fail)
    );

    adc_bist_wdog #(.WD_W(WD_W)) wdog_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .run      (busy),
        .limit    (wd_limit),
        .expire   (expire)
    );

    adc_bist_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .alg_wr     (alg_wr),
        .clr_wr     (clr_wr),
        .rsp_valid  (rsp_valid),
        .win_fail   (win_fail),
        .expire     (expire),
        .start_ok   (start_ok),
        .busy       (busy),
        .conv_req   (conv_req),
        .step       (step_idx),
        .alg        (run_alg),
        .fault_win  (fault_win),
        .fault_wdog (fault_wdog),
        .fail_step  (fail_step)
    );

    assign conv_chan = CHAN_W'(TEST_CHAN);
    assign fault     = fault_win | fault_wdog;
endmodule

// File: rtl/adc_bist_chk.sv
// Protocol and sticky-state assertions for adc_bist_seq, attached by bind.
// Assumes the package step counts.
module adc_bist_chk
    import adc_bist_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              conv_req,
    input logic              run_alg,
    input logic [STEP_W-1:0] step_idx,
    input logic              busy,
    input logic [STEP_W-1:0] fail_step,
    input logic              fault_win,
    input logic              fault_wdog,
    input logic              start_wr,
    input logic              clr_wr
);
    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R1
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (run_alg ? (int'(step_idx) < NUM_CAP) : (int'(step_idx) < NUM_SUP)));

    // R6
    win_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_win && !clr_wr) |=> fault_win);

    // R6
    wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_wdog && !clr_wr) |=> fault_wdog);

    // R5
    first_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_win && !clr_wr) |=> $stable(fail_step));

    // R7
    alg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_wr) |=> $stable(run_alg));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_wdog) |-> !busy);
endmodule

bind adc_bist_seq adc_bist_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_req   (conv_req),
    .run_alg    (run_alg),
    .step_idx   (step_idx),
    .busy       (busy),
    .fail_step  (fail_step),
    .fault_win  (fault_win),
    .fault_wdog (fault_wdog),
    .start_wr   (start_wr),
    .clr_wr     (clr_wr)
);

// File: tb/adc_bist_seq_tb.sv
// Self-checking bench for adc_bist_seq: swept bound cases, capacitive
// first-failure sweep, sticky clear, ignored start, watchdog edge cases.
module adc_bist_seq_tb_top;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [4:0]    wr_addr;
    logic [2*DW-1:0] wr_data;
    logic          conv_req;
    logic [3:0]    conv_chan;
    logic          run_alg;
    logic [3:0]    step_idx;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          busy;
    logic [3:0]    fail_step;
    logic          fault;
    logic          fault_win;
    logic          fault_wdog;

    int checks = 0;
    int errors = 0;
    int lo_s[3], hi_s[3], code_s[3];
    int lo_c[12], hi_c[12], code_c[12];
    int log_step[32], log_alg[32], log_chan[32];
    int log_n = 0;
    int rsp_dly = 0;

    always #10 clk = ~clk;

    adc_bist_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_req(conv_req), .conv_chan(conv_chan), .run_alg(run_alg), .step_idx(step_idx),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .fail_step(fail_step),
        .fault(fault), .fault_win(fault_win), .fault_wdog(fault_wdog)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [2*DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_run(input bit alg);
        wr(5'h18, alg ? 24'd3 : 24'd1);
    endtask

    task automatic clear_faults();
        wr(5'h18, 24'd4);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Checks the logged request sequence against the algorithm (R1, R2).
    task automatic chk_log(input bit alg);
        int nsteps = alg ? 12 : 3;
        bit ok = (log_n == nsteps);
        for (int i = 0; i < nsteps && i < 32; i++)
            if (log_step[i] != i || log_alg[i] != int'(alg)) ok = 1'b0;
        chk(ok, "R1 step order", log_n, nsteps);
        ok = 1'b1;
        for (int i = 0; i < log_n && i < 32; i++)
            if (log_chan[i] != 15) ok = 1'b0;
        chk(ok, "R2 test channel", log_chan[0], 15);
    endtask

    // Converter model: answers each request after rsp_dly+1 cycles.
    initial begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        forever begin
            int ra, rs;
            @(negedge clk);
            rsp_valid = 1'b0;
            if (rst_n === 1'b1 && conv_req === 1'b1) begin
                ra = int'(run_alg);
                rs = int'(step_idx);
                if (log_n < 32) begin
                    log_step[log_n] = rs;
                    log_alg[log_n]  = ra;
                    log_chan[log_n] = int'(conv_chan);
                end
                log_n++;
                repeat (rsp_dly + 1) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = (ra != 0) ? DW'(code_c[rs % 12]) : DW'(code_s[rs % 3]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        for (int k = 0; k < 3; k++) begin
            lo_s[k] = 200 + 300 * k; hi_s[k] = lo_s[k] + 100; code_s[k] = lo_s[k] + 50;
        end
        for (int j = 0; j < 12; j++) begin
            lo_c[j] = 10 + 64 * j; hi_c[j] = lo_c[j] + 40; code_c[j] = lo_c[j] + 20;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(!busy && !conv_req, "R10 busy/req", int'(busy), 0);
        chk(!fault && !fault_win && !fault_wdog, "R10 faults", int'(fault), 0);
        chk(fail_step == 0, "R10 fail_step", int'(fail_step), 0);

        // R4 program bounds: capacitive k at k, supply k at 0x10+k
        for (int k = 0; k < 3; k++)
            wr(5'(16 + k), {DW'(hi_s[k]), DW'(lo_s[k])});
        for (int j = 0; j < 12; j++)
            wr(5'(j), {DW'(hi_c[j]), DW'(lo_c[j])});

        // R1 R2 R3 supply run, all pass
        log_n = 0;
        start_run(1'b0);
        chk(busy == 1'b1, "R7 start accepted", int'(busy), 1);
        wait_idle();
        chk_log(1'b0);
        chk(!fault_win, "R3 all pass", int'(fault_win), 0);

        // R3 R5 bound sweep on each supply step
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 4; c++) begin
                int v;
                bit exp_fail;
                v = (c == 0) ? lo_s[s] - 1 : (c == 1) ? lo_s[s] : (c == 2) ? hi_s[s] : hi_s[s] + 1;
                exp_fail = (v < lo_s[s]) || (v > hi_s[s]);
                clear_faults();
                for (int k = 0; k < 3; k++) code_s[k] = lo_s[k] + 50;
                code_s[s] = v;
                log_n = 0;
                start_run(1'b0);
                wait_idle();
                chk(fault_win == exp_fail, "R3 window bound", int'(fault_win), int'(exp_fail));
                chk(fault == exp_fail, "R3 fault output", int'(fault), int'(exp_fail));
                if (exp_fail) chk(int'(fail_step) == s, "R5 fail step", int'(fail_step), s);
                chk(log_n == 3, "R1 supply count", log_n, 3);
            end
        end
        for (int k = 0; k < 3; k++) code_s[k] = lo_s[k] + 50;

        // R4 R5 capacitive sweep: step k fails high, step 11 fails low too
        for (int k = 0; k < 12; k++) begin
            clear_faults();
            for (int j = 0; j < 12; j++) code_c[j] = lo_c[j] + 20;
            code_c[k] = hi_c[k] + 1;
            if (k < 11) code_c[11] = lo_c[11] - 1;
            log_n = 0;
            start_run(1'b1);
            wait_idle();
            chk_log(1'b1);
            chk(fault_win, "R4 own window", int'(fault_win), 1);
            chk(int'(fail_step) == k, "R5 first failure", int'(fail_step), k);
        end

        // R6 sticky across a passing run, then cleared
        for (int j = 0; j < 12; j++) code_c[j] = lo_c[j] + 20;
        start_run(1'b1);
        wait_idle();
        chk(fault_win && fail_step == 11, "R6 sticky fault", int'(fail_step), 11);
        clear_faults();
        @(negedge clk);
        chk(!fault_win && !fault && fail_step == 0, "R6 cleared", int'(fault_win), 0);

        // R7 start during a run is ignored
        log_n = 0;
        start_run(1'b0);
        wr(5'h18, 24'd3);
        wait_idle();
        chk_log(1'b0);
        repeat (5) @(negedge clk);
        chk(log_n == 3 && !busy, "R7 ignored start", log_n, 3);

        // R8 timeout: limit 5, converter never answers in time
        wr(5'h19, 24'd5);
        rsp_dly = 50;
        log_n = 0;
        start_run(1'b0);
        repeat (5) @(negedge clk);
        chk(busy && !fault_wdog, "R8 before limit", int'(fault_wdog), 0);
        @(negedge clk);
        chk(!busy, "R8 abort", int'(busy), 0);
        chk(fault_wdog && fault, "R8 timeout flag", int'(fault_wdog), 1);
        repeat (70) @(negedge clk);
        chk(log_n == 1, "R8 no more requests", log_n, 1);
        chk(!fault_win, "R9 late response ignored", int'(fault_win), 0);

        // R9 final response on the limit edge: run of 3*(2+1)=9 edges
        rsp_dly = 1;
        clear_faults();
        wr(5'h19, 24'd8);
        log_n = 0;
        start_run(1'b0);
        wait_idle();
        chk(!fault_wdog, "R9 same-edge completion", int'(fault_wdog), 0);
        chk(log_n == 3 && !fault_win, "R9 full run", log_n, 3);

        wr(5'h19, 24'd7);
        log_n = 0;
        start_run(1'b0);
        wait_idle();
        chk(fault_wdog, "R9 one edge short", int'(fault_wdog), 1);
        repeat (5) @(negedge clk);
        chk(log_n == 3 && !fault_win, "R9 late final ignored", log_n, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule